// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a two-wire serial memory protocol engine and a byte-wide storage array. After the engine has received the two address bytes of a write, it loads the start address here. Each data byte it then receives is stored in a page-sized holding buffer at a 7-bit column pointer. The pointer advances and wraps inside the page, and a per-column mask records which columns hold new data.

A STOP that closes a write carrying at least one data byte starts the commit. The block scans every column of the page in ascending order, one per clock. It drives the array write port only for columns whose mask bit is set. After the scan it holds a self-timed busy interval of a configurable number of clocks. The protocol engine uses the busy flag to refuse new commands, for example during acknowledge polling.

A START that arrives while a write is still pending abandons it. This leaves the address counter in place for a random read. When the write-protect input is high at STOP, the bytes have been taken in but nothing is programmed.

Top module: `page_commit`

## Requirements
- R1: After reset, busy and mem_we are 0 and addr_cnt is 0.
- R2: A load of address A, one data byte D and a STOP produce exactly one array write, with mem_addr = A and mem_wdata = D.
- R3: Each accepted data byte advances only addr_cnt[6:0], modulo 128. Bits [15:7] keep the loaded page, and every commit write lies in that page.
- R4: When more than 128 bytes are sent, the column pointer wraps. Each column is written once, holding the last byte that landed in it.
- R5: A partial page writes only the columns that received bytes. All other columns of the page see no write.
- R6: Commit writes come out in ascending column order, at most one per clock.
- R7: A STOP with no data byte since the address load causes no write and no busy period, and addr_cnt keeps the loaded address.
- R8: A START during a pending write discards it, so a later STOP causes no write and no busy. addr_cnt keeps its value.
- R9: With wp = 1 at STOP, bytes still advance addr_cnt, but no write and no busy period follow.
- R10: Busy rises in the cycle after the STOP is sampled. It stays high for exactly 128 + BUSY_CYCLES clocks (the scan, then the timer), and mem_we is high only while busy is high.
- R11: While busy, address loads, data strobes and STOP/START events are ignored. addr_cnt stays unchanged and no extra writes occur.
- R12: After a commit, addr_cnt equals the last written address plus one, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: load addr_in as the start address of a write |
| addr_in | input | 16 | Start address from the protocol engine |
| byte_stb | input | 1 | Strobe: a data byte has been received |
| byte_in | input | 8 | Received data byte |
| start_evt | input | 1 | START condition seen on the bus |
| stop_evt | input | 1 | STOP condition seen on the bus |
| wp | input | 1 | Write protect; high blocks programming |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 16 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit or self-timed interval in progress |
| addr_cnt | output | 16 | Current address counter |

## Verification
The bench targets the page-wrap case. It starts two columns before the page end and sends 130 bytes, so a design that carries into bit 7 would write into the next page. A design that emitted both copies of a column would give 130 writes instead of 128.

A short partial page that crosses the column-127 boundary shows whether unsent columns stay untouched and whether writes come out in ascending order. Aborted writes check that no busy period is started: START before STOP, STOP with no data, and STOP under write protect. Strobes injected during busy would move the counter or add writes in a design that failed to gate them. The busy length is counted exactly, which catches an off-by-one in the scan or the timer.

// File: rtl/page_commit.sv
module page_commit #(
  parameter int ADDR_W      = 16,
  parameter int COL_W       = 7,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_cnt
);
  localparam int PAGE_BYTES = 1 << COL_W;
  localparam int TMR_W      = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_COMMIT, S_WAIT} state_t;

  state_t                 state;
  logic [7:0]             pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  mask;
  logic [COL_W-1:0]       scan;
  logic [TMR_W-1:0]       tmr;
  logic [ADDR_W-1:0]      acnt;

  wire [COL_W-1:0] col    = acnt[COL_W-1:0];
  wire             accept = (state == S_FILL) && byte_stb && !stop_evt && !start_evt && !addr_load;

  assign busy      = (state == S_COMMIT) || (state == S_WAIT);
  assign mem_we    = (state == S_COMMIT) && mask[scan];
  assign mem_addr  = {acnt[ADDR_W-1:COL_W], scan};
  assign mem_wdata = pbuf[scan];
  assign addr_cnt  = acnt;

  always_ff @(posedge clk) begin
    if (accept) pbuf[col] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mask  <= '0;
      scan  <= '0;
      tmr   <= '0;
      acnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (addr_load) begin
            acnt  <= addr_in;
            mask  <= '0;
            state <= S_FILL;
          end
        end
        S_FILL: begin
          if (stop_evt) begin
            if (|mask && !wp) begin
              state <= S_COMMIT;
              scan  <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else if (start_evt) begin
            state <= S_IDLE;
          end else if (addr_load) begin
            acnt <= addr_in;
            mask <= '0;
          end else if (byte_stb) begin
            mask[col]         <= 1'b1;
            acnt[COL_W-1:0]   <= col + 1'b1;
          end
        end
        S_COMMIT: begin
          scan <= scan + 1'b1;
          if (&scan) begin
            state <= S_WAIT;
            tmr   <= '0;
          end
        end
        default: begin
          if (tmr == TMR_W'(BUSY_CYCLES - 1)) state <= S_IDLE;
          else                                tmr   <= tmr + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/page_commit_sva.sv
module page_commit_sva #(
  parameter int ADDR_W = 16,
  parameter int COL_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_evt,
  input logic              wp,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] addr_cnt
);
  a_r10_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r10_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |-> (mem_addr[COL_W-1:0] > $past(mem_addr[COL_W-1:0])));

  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W])));

  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_cnt));

  a_r9_wp_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wp && !busy) |=> !busy);
endmodule

bind page_commit page_commit_sva #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .wp(wp), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .addr_cnt(addr_cnt)
);

// File: tb/page_commit_bench.sv
module page_commit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 40;
  localparam int BUSY_TOTAL = 128 + BUSY_CYC;

  logic        clk = 0, rst_n = 0;
  logic        addr_load = 0, byte_stb = 0, start_evt = 0, stop_evt = 0, wp = 0;
  logic [15:0] addr_in = '0;
  logic [7:0]  byte_in = '0;
  logic        mem_we, busy;
  logic [15:0] mem_addr, addr_cnt;
  logic [7:0]  mem_wdata;

  int errors = 0, checks = 0;
  int nwr = 0, nbusy = 0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];

  page_commit #(.BUSY_CYCLES(BUSY_CYC)) u_page_commit (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .start_evt(start_evt),
    .stop_evt(stop_evt), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .addr_cnt(addr_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_we) begin
      if (nwr < 256) begin
        log_a[nwr] = mem_addr;
        log_d[nwr] = mem_wdata;
      end
      nwr = nwr + 1;
    end
    if (busy) nbusy = nbusy + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    @(posedge clk); #1;
    nwr = 0;
    nbusy = 0;
  endtask

  task automatic do_load(input logic [15:0] a);
    @(posedge clk); #1 addr_load = 1; addr_in = a;
    @(posedge clk); #1 addr_load = 0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(posedge clk); #1 byte_stb = 1; byte_in = d;
    @(posedge clk); #1 byte_stb = 0;
  endtask

  task automatic do_stop();
    @(posedge clk); #1 stop_evt = 1;
    @(posedge clk); #1 stop_evt = 0;
  endtask

  task automatic do_start();
    @(posedge clk); #1 start_evt = 1;
    @(posedge clk); #1 start_evt = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(busy == 0,        "R1 busy", busy, 0);
    check(mem_we == 0,      "R1 mem_we", mem_we, 0);
    check(addr_cnt == 16'h0, "R1 addr_cnt", addr_cnt, 0);
  endtask

  task automatic t_single();
    clr_log();
    do_load(16'h1234); do_byte(8'hA5); do_stop(); wait_done();
    check(nwr == 1, "R2 write count", nwr, 1);
    check(log_a[0] == 16'h1234, "R2 address", log_a[0], 16'h1234);
    check(log_d[0] == 8'hA5, "R2 data", log_d[0], 8'hA5);
    check(nbusy == BUSY_TOTAL, "R10 busy length", nbusy, BUSY_TOTAL);
    check(addr_cnt == 16'h1235, "R12 counter after commit", addr_cnt, 16'h1235);
  endtask

  task automatic t_wrap();
    bit ok = 1;
    clr_log();
    do_load(16'h05FE);
    for (int i = 0; i < 130; i++) do_byte(pat(i));
    check(addr_cnt == 16'h0580, "R3 column wrap keeps page", addr_cnt, 16'h0580);
    do_stop(); wait_done();
    check(nwr == 128, "R4 one write per column", nwr, 128);
    for (int k = 0; k < 128; k++) begin
      if (ok && (log_a[k] != 16'h0580 + 16'(k) || log_d[k] != pat(k + 2))) begin
        ok = 0;
        check(0, "R4 wrapped data/address", {log_a[k], log_d[k]}, {16'h0580 + 16'(k), pat(k + 2)});
      end
    end
    if (ok) check(1, "R4 wrapped data/address", 0, 0);
    check(addr_cnt == 16'h0580, "R12 counter after wrap", addr_cnt, 16'h0580);
  endtask

  task automatic t_partial();
    clr_log();
    do_load(16'hFFF0);
    for (int i = 0; i < 5; i++) do_byte(8'hC0 + 8'(i));
    do_stop(); wait_done();
    check(nwr == 5, "R5 partial count", nwr, 5);
    check(log_a[0] == 16'hFFF0 && log_a[4] == 16'hFFF4, "R5 partial range", log_a[4], 16'hFFF4);
    check(log_d[4] == 8'hC4, "R5 partial data", log_d[4], 8'hC4);
    check(addr_cnt == 16'hFFF5, "R12 partial counter", addr_cnt, 16'hFFF5);
    clr_log();
    do_load(16'h007E);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
    do_stop(); wait_done();
    check(nwr == 3, "R6 cross count", nwr, 3);
    check(log_a[0] == 16'h0000 && log_d[0] == 8'h33, "R6 first in order", {log_a[0], log_d[0]}, {16'h0000, 8'h33});
    check(log_a[1] == 16'h007E && log_d[1] == 8'h11, "R6 second in order", {log_a[1], log_d[1]}, {16'h007E, 8'h11});
    check(log_a[2] == 16'h007F && log_d[2] == 8'h22, "R6 third in order", {log_a[2], log_d[2]}, {16'h007F, 8'h22});
    check(addr_cnt == 16'h0001, "R3 upper bits fixed", addr_cnt, 16'h0001);
  endtask

  task automatic t_stop_empty();
    clr_log();
    do_load(16'h4321); do_stop(); wait_done();
    check(nwr == 0 && nbusy == 0, "R7 no write/busy", {nwr, nbusy}, 0);
    check(addr_cnt == 16'h4321, "R7 counter kept", addr_cnt, 16'h4321);
  endtask

  task automatic t_start_abort();
    clr_log();
    do_load(16'h0A00); do_start(); do_stop(); wait_done();
    check(nwr == 0 && nbusy == 0, "R8 empty abort", {nwr, nbusy}, 0);
    check(addr_cnt == 16'h0A00, "R8 counter for random read", addr_cnt, 16'h0A00);
    clr_log();
    do_load(16'h0B10); do_byte(8'h5A); do_byte(8'h6B); do_start(); do_stop(); wait_done();
    check(nwr == 0 && nbusy == 0, "R8 abort with data", {nwr, nbusy}, 0);
    check(addr_cnt == 16'h0B12, "R8 counter kept", addr_cnt, 16'h0B12);
  endtask

  task automatic t_wp();
    clr_log();
    @(posedge clk); #1 wp = 1;
    do_load(16'h2200);
    do_byte(8'h01); do_byte(8'h02); do_byte(8'h03);
    do_stop(); wait_done();
    check(nwr == 0 && nbusy == 0, "R9 protected", {nwr, nbusy}, 0);
    check(addr_cnt == 16'h2203, "R9 bytes accepted", addr_cnt, 16'h2203);
    @(posedge clk); #1 wp = 0;
  endtask

  task automatic t_busy_ignore();
    clr_log();
    do_load(16'h2000); do_byte(8'h11); do_stop();
    do_load(16'h3333); do_byte(8'h99); do_stop(); do_start();
    @(negedge clk);
    check(addr_cnt == 16'h2001, "R11 counter frozen in busy", addr_cnt, 16'h2001);
    wait_done();
    check(nwr == 1 && log_d[0] == 8'h11, "R11 no extra write", {nwr, log_d[0]}, {32'd1, 8'h11});
    check(nbusy == BUSY_TOTAL, "R11 busy not extended", nbusy, BUSY_TOTAL);
    check(addr_cnt == 16'h2001, "R11 counter after busy", addr_cnt, 16'h2001);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_single();
    t_wrap();
    t_partial();
    t_stop_empty();
    t_start_abort();
    t_wp();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule